// File: doc/BRIEF.md
# Interrupt Flag Aggregation Register

This block gathers three interrupt event sources (periodic tick, alarm match and update-ended) into one active-low interrupt line and one readable status byte. Each source owns a sticky flag that is set by a single-cycle event pulse. A separate control register outside this block supplies one enable bit per source. The interrupt line is asserted while any source has both its flag and its enable set.

Software services the line by reading the status byte. The most significant bit is a summary bit that follows the state of the line exactly. The bits below it show the individual flags. The read is a single-cycle strobe qualified by an address compare. It returns the byte as it stood before the read, and it clears every flag at the end of that cycle. If an event pulse arrives in the same cycle as a clearing read, the event is kept, so no interrupt is lost.

Top module: `irq_flag_agg`

## Requirements
- R1: A one-cycle pulse on `evt_pulse[i]` sets flag i at the next rising clock edge, whatever the value of `src_en[i]`. The source indices are 0 for periodic, 1 for alarm and 2 for update-ended.
- R2: Once set, a flag stays set until a clearing read or a reset.
- R3: `irq_n` is low exactly when, for at least one source i, both flag i and `src_en[i]` are one. It follows changes of `src_en` within the same cycle.
- R4: Bit 7 of the status byte reads one exactly when `irq_n` is low.
- R5: A read hit is `rd_en` high while `rd_addr` equals `STATUS_ADDR`. During a read hit, `rd_data` shows the status byte in the same cycle. In that byte, bit 6 is the periodic flag, bit 5 is the alarm flag and bit 4 is the update-ended flag. All flags are clear after the edge that ends the hit.
- R6: If an event pulse and a read hit occur in the same cycle, the read returns the value from before the event, and the flag of that event is set after the edge.
- R7: While there is no read hit (`rd_en` low, or any other address), `rd_data` is all zero and no flag changes.
- R8: Bits 3 down to 0 of the status byte always read zero.
- R9: A synchronous active-high `rst` clears every flag, which leaves `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | 3 | Event pulses: bit 0 periodic, bit 1 alarm, bit 2 update-ended |
| src_en | input | 3 | Per-source interrupt enables from the control register |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_addr | input | 4 | Register address of the read |
| rd_data | output | 8 | Status byte during a read hit, zero otherwise |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its defaults: three sources, an 8-bit data byte and a 4-bit address with the status register at address 3. This small configuration allows a full sweep of all 64 combinations of flag pattern and enable pattern, checking both the line and the status byte. It also allows a full sweep of all 64 pairs of "flags already set" and "events arriving during the read" for the collision rule. A walk over all 15 non-matching addresses confirms that those reads neither return data nor clear flags.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Source numbering shared by the flag vector and the status byte layout
    typedef enum int unsigned {
        SRC_PERIODIC = 0,
        SRC_ALARM    = 1,
        SRC_UPDATE   = 2
    } irq_src_e;

    localparam int unsigned IRQ_NUM_SRC = 3;
    localparam int unsigned IRQ_DATA_W  = 8;
    localparam int unsigned IRQ_ADDR_W  = 4;

    // Status byte bit that carries source i: packed downward under the summary bit
    function automatic int unsigned src_bit(input int unsigned data_w, input int unsigned idx);
        return data_w - 2 - idx;
    endfunction

endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic clr_req,
    output logic flag_q
);
    typedef struct packed {
        logic flag;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (clr_req)
            cell_d.flag = 1'b0;
        // An event in the clearing cycle wins so that it is not lost
        if (set_pulse)
            cell_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cell_q <= '0;
        else
            cell_q <= cell_d;
    end

    assign flag_q = cell_q.flag;

    a_r1_event_sets: assert property (@(posedge clk) disable iff (rst)
        set_pulse |=> flag_q);

    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_req) |=> flag_q);

    a_r5_clear_on_hit: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_pulse) |=> !flag_q);

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> !flag_q);

endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive #(
    parameter int unsigned NUM_SRC = irq_agg_pkg::IRQ_NUM_SRC
) (
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] src_en,
    output logic               irq_n
);
    logic [NUM_SRC-1:0] gated;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            gated[i] = flags[i] & src_en[i];
        irq_n = (gated == '0);
    end

    always_comb begin
        a_r3_quiet_line: assert (!((flags & src_en) == '0) || irq_n || $isunknown(flags));
    end

endmodule

// File: rtl/irq_status_port.sv
module irq_status_port #(
    parameter int unsigned NUM_SRC     = irq_agg_pkg::IRQ_NUM_SRC,
    parameter int unsigned DATA_W      = irq_agg_pkg::IRQ_DATA_W,
    parameter int unsigned ADDR_W      = irq_agg_pkg::IRQ_ADDR_W,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = '0
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] src_en,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data
);
    import irq_agg_pkg::*;

    logic [DATA_W-1:0] status_word;
    logic              any_pending;

    always_comb begin
        rd_hit      = rd_en && (rd_addr == STATUS_ADDR);
        any_pending = 1'b0;
        status_word = '0;
        for (int unsigned i = 0; i < NUM_SRC; i++) begin
            any_pending = any_pending | (flags[i] & src_en[i]);
            status_word[src_bit(DATA_W, i)] = flags[i];
        end
        status_word[DATA_W-1] = any_pending;
        rd_data = rd_hit ? status_word : '0;
    end

endmodule

// File: rtl/irq_flag_agg.sv
module irq_flag_agg #(
    parameter int unsigned NUM_SRC     = irq_agg_pkg::IRQ_NUM_SRC,
    parameter int unsigned DATA_W      = irq_agg_pkg::IRQ_DATA_W,
    parameter int unsigned ADDR_W      = irq_agg_pkg::IRQ_ADDR_W,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'h3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq_n
);
    localparam int unsigned PAD_W = DATA_W - 1 - NUM_SRC;

    logic [NUM_SRC-1:0] flag_vec;
    logic               clr_hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        irq_flag_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .set_pulse (evt_pulse[g]),
            .clr_req   (clr_hit),
            .flag_q    (flag_vec[g])
        );
    end

    irq_line_drive #(.NUM_SRC(NUM_SRC)) u_line (
        .flags  (flag_vec),
        .src_en (src_en),
        .irq_n  (irq_n)
    );

    irq_status_port #(
        .NUM_SRC     (NUM_SRC),
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_port (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .flags   (flag_vec),
        .src_en  (src_en),
        .rd_hit  (clr_hit),
        .rd_data (rd_data)
    );

    a_r4_summary_mirrors_pin: assert property (@(posedge clk) disable iff (rst)
        clr_hit |-> (rd_data[DATA_W-1] == !irq_n));

    a_r7_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !clr_hit |-> (rd_data == '0));

    a_r7_miss_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        !clr_hit |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec)));

    a_r8_pad_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[PAD_W-1:0] == '0);

    a_r9_line_idle_after_reset: assert property (@(posedge clk)
        rst |=> irq_n);

endmodule

// File: tb/irq_flag_agg_test.sv
module irq_flag_agg_test;
    localparam logic [3:0] SADDR = 4'h3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] evt_pulse = '0;
    logic [2:0] src_en = '0;
    logic       rd_en = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_run = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    irq_flag_agg #(.NUM_SRC(3), .DATA_W(8), .ADDR_W(4), .STATUS_ADDR(SADDR)) uut (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .src_en(src_en),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
    );

    always #4 clk = ~clk;

    // Expected status byte: bit7 summary, bit6 periodic, bit5 alarm, bit4 update
    function automatic logic [7:0] exp_status(input logic [2:0] f, input logic [2:0] e);
        return {|(f & e), f[0], f[1], f[2], 4'b0000};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [2:0] p);
        evt_pulse = p;
        tick();
        evt_pulse = '0;
    endtask

    // Clearing read: checks data in the strobe cycle, then ends the cycle
    task automatic hit_read(input string req, input logic [7:0] exp);
        rd_addr = SADDR;
        rd_en   = 1'b1;
        #1;
        chk(req, rd_data, exp);
        tick();
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        // R9: reset state
        chk("R9 irq_n after reset", {7'b0, irq_n}, 8'h01);
        rst = 1'b0;
        src_en = 3'b111;
        hit_read("R9 flags clear after reset", 8'h00);

        // R1 R2 R3 R4 R5 R8: every flag pattern against every enable pattern
        for (int p = 0; p < 8; p++) begin
            for (int e = 0; e < 8; e++) begin
                src_en = e[2:0];
                pulse(p[2:0]);
                chk("R3 irq_n after events", {7'b0, irq_n}, {7'b0, ~|(p[2:0] & e[2:0])});
                tick(); tick();
                chk("R2 flags held", {7'b0, irq_n}, {7'b0, ~|(p[2:0] & e[2:0])});
                src_en = 3'b111;
                #1;
                chk("R3 enable change same cycle", {7'b0, irq_n}, {7'b0, ~|p[2:0]});
                src_en = e[2:0];
                hit_read("R1 R4 R5 R8 status byte", exp_status(p[2:0], e[2:0]));
                chk("R5 line released after read", {7'b0, irq_n}, 8'h01);
                src_en = 3'b111;
                hit_read("R5 flags cleared", 8'h00);
            end
        end

        // R7: reads at other addresses and with the strobe low
        src_en = 3'b111;
        pulse(3'b111);
        for (int a = 0; a < 16; a++) begin
            if (a[3:0] != SADDR) begin
                rd_addr = a[3:0];
                rd_en   = 1'b1;
                #1;
                chk("R7 miss data zero", rd_data, 8'h00);
                tick();
                rd_en = 1'b0;
                chk("R7 miss keeps line", {7'b0, irq_n}, 8'h00);
            end
        end
        rd_addr = SADDR;
        rd_en   = 1'b0;
        #1;
        chk("R7 strobe low data zero", rd_data, 8'h00);
        tick();
        hit_read("R7 flags survive misses", exp_status(3'b111, 3'b111));

        // R6: all old patterns against all events arriving in the read cycle
        for (int o = 0; o < 8; o++) begin
            for (int n = 0; n < 8; n++) begin
                src_en = 3'b111;
                pulse(o[2:0]);
                evt_pulse = n[2:0];
                hit_read("R6 pre-clear value", exp_status(o[2:0], 3'b111));
                evt_pulse = '0;
                chk("R6 new events kept on line", {7'b0, irq_n}, {7'b0, ~|n[2:0]});
                hit_read("R6 new events in status", exp_status(n[2:0], 3'b111));
            end
        end

        // R9: reset in mid-run
        pulse(3'b111);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R9 mid-run reset line", {7'b0, irq_n}, 8'h01);
        hit_read("R9 mid-run reset flags", 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule